// File: doc/BRIEF.md
# Edge-Started Auto-Reload Timer

This block is an 8-bit down-counter with a companion reload register. It counts events from one of two count sources. The first is a prescaler that divides the instruction clock by 4 or by 16. The second is a tick from elsewhere in the chip, for example the underflow of a neighbouring timer.

When the count passes through zero, the counter refills itself from the reload register. It then emits a one-cycle underflow pulse, which other timers can use as a count source, and it sets a sticky interrupt flag.

Counting can be held back until an edge arrives on an asynchronous external pin. The pin is synchronised first. An edge detector then sets a start latch; the detector can be set for falling edges, rising edges or both. Until that latch is set, no count event reaches the counter. Software loads the counter and the reload register through a single write port. Software can also read both values at any time.

Top module: `edge_start_timer`

## Requirements
- R1: After reset, `cnt_q`, `reload_q`, `irq_flag` and `underflow` are 0, and the start latch is clear.
- R2: A write (`wr_en`=1) while `run_en`=0 loads `wr_data` into both counter and reload register on the next edge. A write while `run_en`=1 changes only the reload register.
- R3: Each count event decrements a non-zero counter by exactly one. A count event requires `run_en`=1, an open start gate and a tick from the selected source.
- R4: A count event when the counter is 0 loads the counter from the reload register. `underflow` is high during that same cycle and at no other time.
- R5: With `src_sel`=0, the prescaler ticks once every 4 enabled cycles when `pre_ratio`=0 and once every 16 when `pre_ratio`=1. Its phase restarts whenever `run_en` is low, so the first tick comes in the 4th (or 16th) cycle with `run_en` high.
- R6: With `src_sel`=1, each cycle in which `alt_tick` is high is a tick, and the prescaler has no effect.
- R7: While `run_en`=0 and no write occurs, the counter holds its value.
- R8: While `sync_en`=1 and the start latch is clear, no count event occurs. `ext_pin` passes through two synchronising flops. The latch is then set by the selected edge: `edge_mode` 2'b00 selects falling, 2'b01 rising, and 2'b10 or 2'b11 both edges.
- R9: With `sync_en`=0 the start latch is cleared on the next edge and counting is not gated by it.
- R10: `irq_flag` is set on the edge that ends an underflow cycle. It stays set until a cycle with `irq_clr`=1 and no underflow. When an underflow and a clear arrive in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external start pin |
| alt_tick | input | 1 | Alternative count source, one pulse per tick |
| src_sel | input | 1 | 0 = prescaler, 1 = `alt_tick` |
| run_en | input | 1 | Count source enable |
| pre_ratio | input | 1 | 0 = divide by 4, 1 = divide by 16 |
| sync_en | input | 1 | Gate counting with the start latch |
| edge_mode | input | 2 | Start edge selection |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write value |
| irq_clr | input | 1 | Clear the interrupt flag |
| cnt_q | output | 8 | Current counter value |
| reload_q | output | 8 | Reload register value |
| underflow | output | 1 | One-cycle underflow pulse |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The hardest cases are the start latch in each edge mode and an interrupt clear that coincides with an underflow.

For the latch, the stimulus loads a known count with `sync_en` set. It confirms the count stays frozen over many prescaler periods, then moves `ext_pin` first in the non-selected direction and then in the selected one. It repeats this after dropping `sync_en` to clear the latch.

For the collision case, the stimulus loads a reload value of 0 and holds `alt_tick` high, so that an underflow occurs every cycle. It then pulses `irq_clr` against that stream.

// File: rtl/est_pkg.sv
package est_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL  = 2'b00,
    EDGE_RISE  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTH2 = 2'b11
  } edge_mode_e;

  // Decide whether a pair of synchronised samples is a valid start edge
  function automatic logic edge_valid(input logic [1:0] mode, input logic prev, input logic cur);
    case (edge_mode_e'(mode))
      EDGE_FALL: return prev & ~cur;
      EDGE_RISE: return ~prev & cur;
      default:   return prev ^ cur;
    endcase
  endfunction
endpackage

// File: rtl/est_prescaler.sv
module est_prescaler #(
  parameter int LO_LOG2 = 2,
  parameter int HI_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic ratio_sel,
  output logic tick
);
  localparam int PW = HI_LOG2;
  localparam logic [PW-1:0] LAST_LO = PW'((1 << LO_LOG2) - 1);
  localparam logic [PW-1:0] LAST_HI = PW'((1 << HI_LOG2) - 1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] last;

  assign last = ratio_sel ? LAST_HI : LAST_LO;
  assign tick = run_en && (phase_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (!run_en) phase_q <= '0;
    else if (tick)   phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/est_start_gate.sv
module est_start_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic       sync_en,
  input  logic [1:0] edge_mode,
  output logic       edge_hit,
  output logic       latch_q
);
  import est_pkg::*;

  // shift chain: SYNC_STAGES synchroniser flops plus one history flop
  logic [SYNC_STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_STAGES-1:0], pin};
  end

  assign edge_hit = edge_valid(edge_mode, chain_q[SYNC_STAGES], chain_q[SYNC_STAGES-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= 1'b0;
    else if (!sync_en) latch_q <= 1'b0;
    else if (edge_hit) latch_q <= 1'b1;
  end
endmodule

// File: rtl/est_down_counter.sv
module est_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         count_evt,
  input  logic         run_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] reload_q,
  output logic         at_zero_evt
);
  logic is_zero;

  assign is_zero     = (cnt_q == '0);
  assign at_zero_evt = count_evt && is_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (wr_en && !run_en) begin
      cnt_q    <= wr_data;
      reload_q <= wr_data;
    end else begin
      if (wr_en)     reload_q <= wr_data;
      if (count_evt) cnt_q    <= is_zero ? reload_q : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/edge_start_timer.sv
module edge_start_timer #(
  parameter int CNT_W       = 8,
  parameter int PRE_LO_LOG2 = 2,
  parameter int PRE_HI_LOG2 = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pin,
  input  logic             alt_tick,
  input  logic             src_sel,
  input  logic             run_en,
  input  logic             pre_ratio,
  input  logic             sync_en,
  input  logic [1:0]       edge_mode,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             underflow,
  output logic             irq_flag
);
  // named internal events, observed by the bound checker
  logic pre_tick;
  logic src_tick;
  logic edge_hit;
  logic start_latch;
  logic gate_open;
  logic count_evt;

  est_prescaler #(.LO_LOG2(PRE_LO_LOG2), .HI_LOG2(PRE_HI_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ratio_sel(pre_ratio), .tick(pre_tick)
  );

  est_start_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .sync_en(sync_en),
    .edge_mode(edge_mode), .edge_hit(edge_hit), .latch_q(start_latch)
  );

  assign src_tick  = src_sel ? alt_tick : pre_tick;
  assign gate_open = !sync_en || start_latch;
  assign count_evt = run_en && gate_open && src_tick;

  est_down_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .count_evt(count_evt), .run_en(run_en),
    .wr_en(wr_en), .wr_data(wr_data), .cnt_q(cnt_q), .reload_q(reload_q),
    .at_zero_evt(underflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_flag <= 1'b0;
    else if (underflow) irq_flag <= 1'b1;
    else if (irq_clr)   irq_flag <= 1'b0;
  end
endmodule

// File: rtl/est_timer_chk.sv
module est_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             sync_en,
  input logic             wr_en,
  input logic             irq_clr,
  input logic             count_evt,
  input logic             start_latch,
  input logic             underflow,
  input logic             irq_flag,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q
);
  // R3
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_evt && cnt_q != '0 && !(wr_en && !run_en)) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !(wr_en && !run_en)) |=> cnt_q == $past(reload_q));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_en) |=> $stable(cnt_q));

  // R8
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && !start_latch) |-> !count_evt);

  // R9
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> !start_latch);

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> irq_flag);

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);
endmodule

bind edge_start_timer est_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .sync_en(sync_en), .wr_en(wr_en),
  .irq_clr(irq_clr), .count_evt(count_evt), .start_latch(start_latch),
  .underflow(underflow), .irq_flag(irq_flag), .cnt_q(cnt_q), .reload_q(reload_q)
);

// File: tb/tb_edge_start_timer.sv
`timescale 1ns/1ps
module tb_edge_start_timer;
  logic clk = 0;
  logic rst_n = 0;
  logic ext_pin = 0, alt_tick = 0, src_sel = 0, run_en = 0, pre_ratio = 0, sync_en = 0;
  logic [1:0] edge_mode = 2'b00;
  logic wr_en = 0, irq_clr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] cnt_q, reload_q;
  logic underflow, irq_flag;

  int checks = 0, fails = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  edge_start_timer dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .alt_tick(alt_tick), .src_sel(src_sel),
    .run_en(run_en), .pre_ratio(pre_ratio), .sync_en(sync_en), .edge_mode(edge_mode),
    .wr_en(wr_en), .wr_data(wr_data), .irq_clr(irq_clr), .cnt_q(cnt_q),
    .reload_q(reload_q), .underflow(underflow), .irq_flag(irq_flag)
  );

  // behavioural reference model
  int m_cnt = 0, m_rld = 0, m_irq = 0, m_latch = 0, m_since = 0;
  int hist[$] = '{0, 0, 0};   // [0] newest pin sample ... [2] oldest

  function automatic int m_evt();
    int div;
    int ptick, src, gate;
    div   = pre_ratio ? 16 : 4;
    ptick = run_en && (m_since + 1 >= div);
    src   = src_sel ? int'(alt_tick) : ptick;
    gate  = !sync_en || m_latch;
    return (run_en && gate && src) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rld = 0; m_irq = 0; m_latch = 0; m_since = 0;
      hist = '{0, 0, 0};
    end else begin
      int evt, uf, old_rld, hit, div;
      evt = m_evt();
      uf  = evt && (m_cnt == 0);
      old_rld = m_rld;
      div = pre_ratio ? 16 : 4;
      case (edge_mode)
        2'b00:   hit = (hist[2] == 1) && (hist[1] == 0);
        2'b01:   hit = (hist[2] == 0) && (hist[1] == 1);
        default: hit = (hist[2] != hist[1]);
      endcase
      if (wr_en && !run_en) begin
        m_cnt = wr_data; m_rld = wr_data;
      end else begin
        if (wr_en) m_rld = wr_data;
        if (evt) m_cnt = (m_cnt == 0) ? old_rld : m_cnt - 1;
      end
      if (uf) m_irq = 1; else if (irq_clr) m_irq = 0;
      if (!sync_en) m_latch = 0; else if (hit) m_latch = 1;
      if (!run_en || (m_since + 1 >= div)) m_since = 0; else m_since++;
      hist.push_front(int'(ext_pin));
      void'(hist.pop_back());
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(phase, "cnt_q (R3)", cnt_q, m_cnt);
      chk(phase, "reload_q (R2)", reload_q, m_rld);
      chk(phase, "irq_flag (R10)", irq_flag, m_irq);
      chk(phase, "underflow (R4)", underflow, (m_evt() && m_cnt == 0) ? 1 : 0);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1 reset state
    step(3);
    chk("R1", "cnt_q in reset", cnt_q, 0);
    chk("R1", "irq_flag in reset", irq_flag, 0);
    rst_n = 1;
    step(2);
    chk("R1", "cnt_q after reset", cnt_q, 0);
    chk("R1", "reload_q after reset", reload_q, 0);
    chk("R1", "underflow after reset", underflow, 0);

    // R2 write while stopped
    phase = "R2";
    wr_en = 1; wr_data = 8'd5; step(1); wr_en = 0; step(1);
    chk("R2", "cnt_q loaded", cnt_q, 5);
    chk("R2", "reload_q loaded", reload_q, 5);

    // R5 divide by 4, R3/R4 counting and reload
    phase = "R5"; run_en = 1; step(40);
    phase = "R4"; step(20);
    // R2 write while running: reload only
    phase = "R2"; wr_en = 1; wr_data = 8'd9; step(1); wr_en = 0; step(60);

    // R7 stop
    phase = "R7"; run_en = 0; step(12);
    chk("R7", "hold while stopped", cnt_q, m_cnt);

    // R6 alternative source
    phase = "R6"; src_sel = 1; run_en = 1;
    for (int i = 0; i < 30; i++) begin alt_tick = (i % 3 == 0); step(1); end
    alt_tick = 0; src_sel = 0;

    // R5 divide by 16
    phase = "R5"; pre_ratio = 1; step(100);
    pre_ratio = 0;

    // R8 start gate, falling edge
    phase = "R8"; run_en = 0; wr_en = 1; wr_data = 8'd3; step(1); wr_en = 0;
    ext_pin = 1; sync_en = 1; edge_mode = 2'b00; step(6);
    run_en = 1; step(30);
    chk("R8", "frozen before edge", cnt_q, 3);
    ext_pin = 0; step(30);

    // R9 sync disabled clears latch
    phase = "R9"; sync_en = 0; step(3); sync_en = 1;
    phase = "R8"; edge_mode = 2'b01; step(20);
    ext_pin = 1; step(20);
    ext_pin = 0; sync_en = 0; step(2); sync_en = 1; edge_mode = 2'b10; step(20);
    ext_pin = 1; step(20);
    sync_en = 0; step(2); sync_en = 1; edge_mode = 2'b11; ext_pin = 0; step(20);
    phase = "R9"; sync_en = 0; ext_pin = 1; step(20);

    // R10 clear against continuous underflow, then isolated clear
    phase = "R10"; run_en = 0; wr_en = 1; wr_data = 8'd0; step(1); wr_en = 0;
    src_sel = 1; alt_tick = 1; run_en = 1; step(3);
    irq_clr = 1; step(2); irq_clr = 0; step(1);
    alt_tick = 0; step(3);
    chk("R10", "flag sticky", irq_flag, 1);
    irq_clr = 1; step(1); irq_clr = 0; step(1);
    chk("R10", "flag cleared", irq_flag, 0);
    step(5);
    summary();
  end
endmodule